// File: doc/BRIEF.md
# I/O Chain Request Router with Compatibility Fallback

A host that drives several independent point-to-point I/O chains has to decide, for every outgoing I/O request, which chain carries it. On a shared bus an unclaimed request can be detected by watching for no device responding. On point-to-point links nothing can observe that, so the host settles it in advance. It holds a table of positive-decode windows that software programs, one for each range of addresses owned by a device or bridge. Each window names the chain on which its owner lives.

Every request address is compared against all windows at once. A hit steers the request to the window's chain with the compat flag low. A miss steers it to one programmable compatibility chain with the compat flag high, and the subtractive bridge on that chain then claims the request whatever its address is. A window may point at the compatibility chain itself. Such a hit still leaves the flag low.

The request side and the output side both use valid/ready handshakes. The output side is a registered stage driven by a two-state machine. `ST_EMPTY` holds nothing. `ST_FULL` holds one routed request, and its `out_valid` output comes from a register. The transitions are:

- LOAD: `ST_EMPTY` to `ST_FULL` on an accepted request.
- REFILL: `ST_FULL` to `ST_FULL` when the held request leaves and a new one is taken in the same cycle.
- STALL: `ST_FULL` to `ST_FULL` when `out_ready` is low.
- DRAIN: `ST_FULL` to `ST_EMPTY` when the held request leaves and no new one arrives.

Top module: `io_chain_steer`

## Requirements
- R1: After reset `out_valid` is 0, `req_ready` is 1, every window is disabled and the compatibility chain ID is 0, so the first request goes to chain 0 with `out_compat`=1.
- R2: A request whose address lies inside an enabled window appears on the output with `out_chain` equal to that window's chain ID, `out_compat`=0, and `out_addr` equal to the request address.
- R3: A request that lies inside no enabled window appears with `out_chain` equal to the compatibility chain register and `out_compat`=1.
- R4: A window whose enable bit is 0 never matches, whatever its base and limit. Setting the enable bit makes the same address match.
- R5: Window bounds are inclusive. An address equal to the base or to the limit matches. Base-1 and limit+1 do not match.
- R6: When several enabled windows match, the window with the lowest index decides the chain.
- R7: A hit on a window whose chain ID equals the compatibility chain still gives `out_compat`=0.
- R8: While `out_valid`=1 and `out_ready`=0, `req_ready` is 0 and `out_addr`, `out_chain` and `out_compat` hold their values.
- R9: A request accepted at a clock edge is presented with `out_valid`=1 right after that edge. When `out_ready` stays 1, one request per cycle passes. When the held request leaves and no new request is accepted, `out_valid` drops after that edge.
- R10: Configuration map: `cfg_addr` = {entry[CFG_AW-1:2], field[1:0]}. For entry < N_RANGES, field 0 writes the base, field 1 writes the limit, and field 2 writes control, with the enable in bit CHAIN_W and the chain ID in bits [CHAIN_W-1:0]. Entry N_RANGES with field 0 writes the compatibility chain ID. A write to any other address changes no routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register select {entry, field} |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | ADDR_W | Incoming request address |
| out_valid | output | 1 | Routed request valid (registered) |
| out_ready | input | 1 | Downstream accepts the routed request |
| out_addr | output | ADDR_W | Address of the routed request |
| out_chain | output | CHAIN_W | Destination chain ID |
| out_compat | output | 1 | Set when no window claimed the request |

## Verification
The bench builds the router with its default parameters: 32-bit addresses, four windows and a 2-bit chain ID. With four windows the bench can make two windows overlap, hold one window disabled, and point one window at the compatibility chain, all in the same table. With a 2-bit chain ID every destination can be given a distinct value, so a misrouted request always shows up as a wrong chain number. The directed scenarios probe each window edge at base, base-1, limit and limit+1. They also hold the output stalled while a second request waits, and check that writes to unmapped configuration addresses leave routing unchanged.

// File: rtl/io_steer_pkg.sv
package io_steer_pkg;

    // Configuration field selectors inside one entry
    localparam logic [1:0] FLD_BASE  = 2'd0;
    localparam logic [1:0] FLD_LIMIT = 2'd1;
    localparam logic [1:0] FLD_CTRL  = 2'd2;
    localparam logic [1:0] FLD_COMPAT = 2'd0;  // used with entry == N_RANGES

    // Output stage states
    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;

endpackage

// File: rtl/io_steer_regs.sv
module io_steer_regs
    import io_steer_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int N_RANGES = 4,
    parameter int CHAIN_W  = 2,
    parameter int CFG_AW   = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CFG_AW-1:0]                 cfg_addr,
    input  logic [ADDR_W-1:0]                 cfg_wdata,
    output logic [N_RANGES-1:0][ADDR_W-1:0]   base_q,
    output logic [N_RANGES-1:0][ADDR_W-1:0]   limit_q,
    output logic [N_RANGES-1:0]               en_q,
    output logic [N_RANGES-1:0][CHAIN_W-1:0]  chain_q,
    output logic [CHAIN_W-1:0]                compat_q
);
    localparam int ENTRY_W = CFG_AW - 2;

    logic [ENTRY_W-1:0] sel_entry;
    logic [1:0]         sel_field;

    assign sel_entry = cfg_addr[CFG_AW-1:2];
    assign sel_field = cfg_addr[1:0];

    // One register group per window
    for (genvar g = 0; g < N_RANGES; g++) begin : g_win
        logic hit_entry;
        assign hit_entry = cfg_we && (sel_entry == ENTRY_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                en_q[g]    <= 1'b0;
                chain_q[g] <= '0;
            end else if (hit_entry) begin
                unique case (sel_field)
                    FLD_BASE:  base_q[g]  <= cfg_wdata;
                    FLD_LIMIT: limit_q[g] <= cfg_wdata;
                    FLD_CTRL: begin
                        en_q[g]    <= cfg_wdata[CHAIN_W];
                        chain_q[g] <= cfg_wdata[CHAIN_W-1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Compatibility chain register sits past the last window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            compat_q <= '0;
        end else if (cfg_we && sel_entry == ENTRY_W'(N_RANGES)
                     && sel_field == FLD_COMPAT) begin
            compat_q <= cfg_wdata[CHAIN_W-1:0];
        end
    end

endmodule

// File: rtl/io_steer_match.sv
module io_steer_match #(
    parameter int ADDR_W   = 32,
    parameter int N_RANGES = 4,
    parameter int CHAIN_W  = 2
) (
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [N_RANGES-1:0][ADDR_W-1:0]   base_q,
    input  logic [N_RANGES-1:0][ADDR_W-1:0]   limit_q,
    input  logic [N_RANGES-1:0]               en_q,
    input  logic [N_RANGES-1:0][CHAIN_W-1:0]  chain_q,
    input  logic [CHAIN_W-1:0]                compat_q,
    output logic                              hit,
    output logic [CHAIN_W-1:0]                dest_chain,
    output logic                              dest_compat
);
    logic [N_RANGES-1:0] in_win;

    // Parallel inclusive window compare
    for (genvar g = 0; g < N_RANGES; g++) begin : g_cmp
        assign in_win[g] = en_q[g] && (addr >= base_q[g]) && (addr <= limit_q[g]);
    end

    // Lowest index wins: scan downward so the last write is the lowest hit
    logic [CHAIN_W-1:0] win_chain;
    always_comb begin
        win_chain = '0;
        for (int i = N_RANGES - 1; i >= 0; i--) begin
            if (in_win[i]) win_chain = chain_q[i];
        end
    end

    assign hit         = |in_win;
    assign dest_chain  = hit ? win_chain : compat_q;
    assign dest_compat = !hit;

endmodule

// File: rtl/io_steer_stage.sv
module io_steer_stage
    import io_steer_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CHAIN_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [CHAIN_W-1:0] dest_chain,
    input  logic               dest_compat,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [CHAIN_W-1:0] out_chain,
    output logic               out_compat
);
    stage_state_e state_q, state_d;
    logic         accept;

    assign req_ready = (state_q == ST_EMPTY) || out_ready;
    assign accept    = req_valid && req_ready;

    // Next-state: LOAD, REFILL, STALL, DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = accept ? ST_FULL : ST_EMPTY;          // LOAD
            ST_FULL: begin
                if (out_ready && !accept) state_d = ST_EMPTY;          // DRAIN
                else                      state_d = ST_FULL;           // REFILL / STALL
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Output payload register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr   <= '0;
            out_chain  <= '0;
            out_compat <= 1'b0;
        end else if (accept) begin
            out_addr   <= req_addr;
            out_chain  <= dest_chain;
            out_compat <= dest_compat;
        end
    end

    assign out_valid = (state_q == ST_FULL);

endmodule

// File: rtl/io_chain_steer.sv
module io_chain_steer
    import io_steer_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int N_RANGES = 4,
    parameter int CHAIN_W  = 2,
    localparam int CFG_AW  = $clog2(N_RANGES + 1) + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [CHAIN_W-1:0] out_chain,
    output logic               out_compat
);
    logic [N_RANGES-1:0][ADDR_W-1:0]  base_q;
    logic [N_RANGES-1:0][ADDR_W-1:0]  limit_q;
    logic [N_RANGES-1:0]              en_q;
    logic [N_RANGES-1:0][CHAIN_W-1:0] chain_q;
    logic [CHAIN_W-1:0]               compat_chain;
    logic                             match_hit;
    logic [CHAIN_W-1:0]               match_chain;
    logic                             match_compat;

    io_steer_regs #(
        .ADDR_W(ADDR_W), .N_RANGES(N_RANGES), .CHAIN_W(CHAIN_W), .CFG_AW(CFG_AW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .base_q(base_q), .limit_q(limit_q), .en_q(en_q),
        .chain_q(chain_q), .compat_q(compat_chain)
    );

    io_steer_match #(
        .ADDR_W(ADDR_W), .N_RANGES(N_RANGES), .CHAIN_W(CHAIN_W)
    ) match_i (
        .addr(req_addr),
        .base_q(base_q), .limit_q(limit_q), .en_q(en_q),
        .chain_q(chain_q), .compat_q(compat_chain),
        .hit(match_hit), .dest_chain(match_chain), .dest_compat(match_compat)
    );

    io_steer_stage #(
        .ADDR_W(ADDR_W), .CHAIN_W(CHAIN_W)
    ) stage_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .dest_chain(match_chain), .dest_compat(match_compat),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_chain(out_chain), .out_compat(out_compat)
    );

endmodule

// File: rtl/io_chain_steer_chk.sv
module io_chain_steer_chk #(
    parameter int ADDR_W  = 32,
    parameter int CHAIN_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               out_valid,
    input logic               out_ready,
    input logic [ADDR_W-1:0]  out_addr,
    input logic [CHAIN_W-1:0] out_chain,
    input logic               out_compat,
    input logic               match_hit,
    input logic [CHAIN_W-1:0] compat_chain
);
    // R8: stalled output keeps its payload
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
                                   && $stable(out_chain) && $stable(out_compat));

    // R8: no intake while stalled
    a_r8_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !req_ready);

    // R9: an accepted request appears right after its edge
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> out_valid && out_addr == $past(req_addr));

    // R9: drain when nothing new arrives
    a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !(req_valid && req_ready) |=> !out_valid);

    // R3: a miss is flagged and sent to the compatibility chain
    a_r3_miss_route: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !match_hit |=> out_compat && out_chain == $past(compat_chain));

    // R2: a hit is never flagged
    a_r2_hit_clear: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && match_hit |=> !out_compat);

endmodule

bind io_chain_steer io_chain_steer_chk #(
    .ADDR_W(ADDR_W), .CHAIN_W(CHAIN_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_chain(out_chain), .out_compat(out_compat),
    .match_hit(match_hit), .compat_chain(compat_chain)
);

// File: tb/io_chain_steer_tb.sv
module io_chain_steer_tb_top;
    localparam int ADDR_W   = 32;
    localparam int N_RANGES = 4;
    localparam int CHAIN_W  = 2;
    localparam int CFG_AW   = $clog2(N_RANGES + 1) + 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [CFG_AW-1:0]  cfg_addr = '0;
    logic [ADDR_W-1:0]  cfg_wdata = '0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [ADDR_W-1:0]  req_addr = '0;
    logic               out_valid;
    logic               out_ready = 1'b1;
    logic [ADDR_W-1:0]  out_addr;
    logic [CHAIN_W-1:0] out_chain;
    logic               out_compat;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    io_chain_steer #(.ADDR_W(ADDR_W), .N_RANGES(N_RANGES), .CHAIN_W(CHAIN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_chain(out_chain), .out_compat(out_compat)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [CFG_AW-1:0] caddr(input int entry, input int field);
        return {entry[CFG_AW-3:0], field[1:0]};
    endfunction

    task automatic cfg_write(input int entry, input int field, input logic [ADDR_W-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = caddr(entry, field); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_window(input int entry, input logic [ADDR_W-1:0] lo,
                              input logic [ADDR_W-1:0] hi, input bit en, input int chain);
        cfg_write(entry, 0, lo);
        cfg_write(entry, 1, hi);
        cfg_write(entry, 2, ADDR_W'({en, chain[CHAIN_W-1:0]}));
    endtask

    // Send one request with out_ready high and check the routed result
    task automatic route(input string tag, input logic [ADDR_W-1:0] a,
                         input int exp_chain, input bit exp_compat);
        @(negedge clk);
        out_ready = 1'b1; req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"},  64'(out_valid), 64'd1);
        check({tag, " addr"},   64'(out_addr), 64'(a));
        check({tag, " chain"},  64'(out_chain), 64'(exp_chain));
        check({tag, " compat"}, 64'(out_compat), 64'(exp_compat));
    endtask

    task automatic t_reset;
        check("R1 out_valid after reset", 64'(out_valid), 64'd0);
        check("R1 req_ready after reset", 64'(req_ready), 64'd1);
        route("R1 default route", 32'h0000_1234, 0, 1'b1);
    endtask

    task automatic t_program;
        cfg_write(N_RANGES, 0, 32'd3);                    // compat chain = 3
        set_window(0, 32'h1000, 32'h1FFF, 1'b1, 1);
        set_window(1, 32'h1800, 32'h27FF, 1'b1, 2);
        set_window(2, 32'h8000, 32'h8FFF, 1'b1, 3);
        set_window(3, 32'h4000, 32'h4FFF, 1'b0, 2);       // disabled
    endtask

    task automatic t_hits_and_misses;
        route("R2 hit window0", 32'h0000_1400, 1, 1'b0);
        route("R2 hit window1", 32'h0000_2100, 2, 1'b0);
        route("R3 miss high",   32'hF000_0000, 3, 1'b1);
        route("R7 hit on compat chain", 32'h0000_8800, 3, 1'b0);
        route("R6 overlap lowest wins", 32'h0000_1900, 1, 1'b0);
    endtask

    task automatic t_bounds;
        route("R5 base",    32'h0000_1000, 1, 1'b0);
        route("R5 base-1",  32'h0000_0FFF, 3, 1'b1);
        route("R5 limit",   32'h0000_27FF, 2, 1'b0);
        route("R5 limit+1", 32'h0000_2800, 3, 1'b1);
    endtask

    task automatic t_enable;
        route("R4 disabled window ignored", 32'h0000_4800, 3, 1'b1);
        cfg_write(3, 2, ADDR_W'({1'b1, 2'd2}));
        route("R4 enabled window matches", 32'h0000_4800, 2, 1'b0);
    endtask

    task automatic t_unmapped_cfg;
        cfg_write(N_RANGES, 1, 32'd1);   // unmapped field
        cfg_write(N_RANGES, 3, 32'd2);   // unmapped field
        route("R10 unmapped write no effect", 32'h0000_0010, 3, 1'b1);
        cfg_write(N_RANGES, 0, 32'd0);
        route("R10 compat register moved", 32'h0000_0010, 0, 1'b1);
        cfg_write(N_RANGES, 0, 32'd3);
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        out_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h0000_1100;
        @(negedge clk);
        check("R8 first held valid", 64'(out_valid), 64'd1);
        check("R8 req_ready low while stalled", 64'(req_ready), 64'd0);
        req_addr = 32'hF000_0004;
        @(negedge clk);
        @(negedge clk);
        check("R8 addr held", 64'(out_addr), 64'h1100);
        check("R8 chain held", 64'(out_chain), 64'd1);
        check("R8 compat held", 64'(out_compat), 64'd0);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 refill addr", 64'(out_addr), 64'hF000_0004);
        check("R9 refill chain", 64'(out_chain), 64'd3);
        check("R9 refill compat", 64'(out_compat), 64'd1);
        @(negedge clk);
        check("R9 drain", 64'(out_valid), 64'd0);
    endtask

    task automatic t_stream;
        logic [ADDR_W-1:0] seq [3] = '{32'h0000_1004, 32'h0000_2004, 32'h0000_3004};
        int exp_ch [3] = '{1, 2, 3};
        @(negedge clk);
        out_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            req_valid = 1'b1; req_addr = seq[i];
            @(negedge clk);
            check("R9 stream valid", 64'(out_valid), 64'd1);
            check("R9 stream addr", 64'(out_addr), 64'(seq[i]));
            check("R9 stream chain", 64'(out_chain), 64'(exp_ch[i]));
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 stream drained", 64'(out_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_program;
        t_hits_and_misses;
        t_bounds;
        t_enable;
        t_unmapped_cfg;
        t_backpressure;
        t_stream;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule